// File: doc/BRIEF.md
# Macroblock Input Frame Acceptor

This block sits at the receiving end of a compressed-video path. Macroblocks arrive one byte at a time, with a byte strobe that is only asserted while the data bus holds a valid byte and that pulses at no more than a quarter of the clock rate. The block pairs the bytes into 16-bit words and writes each word to a frame store through a simple write port. The write address moves through a store deep enough for more than three full-size frames and wraps to zero at the end. There are no fixed buffer slots.

A frame-sync level input frames each picture. Its rising edge latches the picture size (large or small), records the current write address as the start of the frame, and clears the word and macroblock counters. The frame is accepted only if sync stays high until the full macroblock count has arrived. If sync falls early, the partial frame is thrown away, the write pointer goes back to the start of that frame so the space is reused, and a sticky error flag is raised. A complete frame becomes pending. The display side picks it up on the next field-end pulse and does not wait for a frame boundary. Until then, and for as long as no newer frame arrives, the display base stays on the previous frame.

Top module: `mb_frame_acceptor`

## Requirements
- R1: Each pair of accepted bytes forms one word, with the first byte in bits 15:8 and the second in bits 7:0. The word appears on `wr_data`, with `wr_en` high for one cycle, in the cycle after the second byte is accepted.
- R2: A rising edge of `frame_sync` latches `cif_mode`, sets the frame start to the current write pointer and clears the word, macroblock and byte-pairing state. The first word of the frame is written at that start address.
- R3: A byte is accepted only when `byte_stb` is high, `frame_sync` is high and a frame is in progress. Strobes while sync is low cause no write. The strobe must be low for at least the cycle after each pulse.
- R4: A frame is complete after CIF_MBS macroblocks when `cif_mode` was 1 at the sync edge, or after QCIF_MBS macroblocks when it was 0. Each macroblock is MB_BYTES bytes. `frame_commit` pulses together with the `wr_en` of the last word. Further bytes are ignored until the next sync edge.
- R5: If `frame_sync` falls before the frame is complete, no commit occurs, `sync_err` is set in the next cycle, and the write pointer returns to that frame's start address.
- R6: `sync_err` stays set until the next completed frame and is low in the cycle `frame_commit` is high.
- R7: `disp_base` changes only in the cycle after a `field_end` pulse for which a committed frame is pending. It then takes the start address of the most recent committed frame. Otherwise it holds.
- R8: The write address advances by one per word and wraps from STORE_WORDS-1 to 0.
- R9: After reset `wr_en`, `frame_commit` and `sync_err` are 0, and `disp_base` and the write pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cif_mode | input | 1 | 1 = large frame, 0 = small frame; sampled at the sync rising edge |
| frame_sync | input | 1 | Frame-sync level; high for the whole frame |
| byte_stb | input | 1 | Input byte strobe |
| byte_in | input | 8 | Input byte |
| field_end | input | 1 | One-cycle pulse at the end of each display field |
| wr_en | output | 1 | Frame-store word write enable |
| wr_addr | output | ADDR_W | Frame-store word address |
| wr_data | output | 16 | Frame-store word data |
| disp_base | output | ADDR_W | Start address of the frame currently displayed |
| frame_commit | output | 1 | Pulse when a frame completes |
| sync_err | output | 1 | Sticky flag for a frame dropped by an early sync fall |

## Verification
A wrong byte-pairing phase shows on the very next `wr_en` as swapped or shifted halves in `wr_data`. A wrong frame start or a pointer that was not restored shows on the first `wr_addr` of the following frame. A wrong macroblock count shows as `frame_commit` on the wrong word, or as extra writes after completion. A wrong pending state only shows at the next `field_end`, as a `disp_base` that moved when it should have held, or held when it should have moved. The bench therefore pulses `field_end` after each scenario.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  // macroblocks expected for the size latched at the sync edge
  function automatic int frame_mbs(input logic cif, input int cif_n, input int qcif_n);
    return cif ? cif_n : qcif_n;
  endfunction

  // next word address in a store of 'depth' words, wrapping to zero
  function automatic int ptr_next(input int p, input int depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/mfa_packer.sv
module mfa_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        byte_acc,
  input  logic [7:0]  byte_in,
  output logic        pair_done,
  output logic [15:0] word
);
  logic       have_hi;
  logic [7:0] hi_q;

  assign pair_done = byte_acc && have_hi;
  assign word      = {hi_q, byte_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hi <= 1'b0;
      hi_q    <= '0;
    end else if (clear) begin
      have_hi <= 1'b0;
    end else if (byte_acc) begin
      have_hi <= !have_hi;
      if (!have_hi) hi_q <= byte_in;
    end
  end
endmodule

// File: rtl/mfa_frame_ctl.sv
module mfa_frame_ctl import mfa_pkg::*; #(
  parameter int STORE_WORDS = 262144,
  parameter int ADDR_W      = 18,
  parameter int WPM         = 192,
  parameter int CIF_MBS     = 396,
  parameter int QCIF_MBS    = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cif_mode,
  input  logic              frame_sync,
  input  logic              byte_stb,
  input  logic              pair_done,
  output logic              byte_acc,
  output logic              sync_rise,
  output logic              early_drop,
  output logic              frame_done,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] frame_start
);
  localparam int WIM_W = (WPM > 1) ? $clog2(WPM) : 1;
  localparam int MB_W  = $clog2(CIF_MBS + 1);

  logic             sync_q, mode_q, rx_active;
  logic [WIM_W-1:0] wim_cnt;
  logic [MB_W-1:0]  mb_cnt;
  logic             mb_last_word, last_mb;

  assign sync_rise    = frame_sync && !sync_q;
  assign byte_acc     = rx_active && frame_sync && byte_stb;
  assign early_drop   = rx_active && !frame_sync;
  assign mb_last_word = (wim_cnt == WIM_W'(WPM - 1));
  assign last_mb      = (mb_cnt == MB_W'(frame_mbs(mode_q, CIF_MBS, QCIF_MBS) - 1));
  assign frame_done   = pair_done && mb_last_word && last_mb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      mode_q      <= 1'b0;
      rx_active   <= 1'b0;
      wim_cnt     <= '0;
      mb_cnt      <= '0;
      wr_ptr      <= '0;
      frame_start <= '0;
    end else begin
      sync_q <= frame_sync;
      if (sync_rise) begin
        mode_q      <= cif_mode;
        rx_active   <= 1'b1;
        wim_cnt     <= '0;
        mb_cnt      <= '0;
        frame_start <= wr_ptr;
      end else if (early_drop) begin
        rx_active <= 1'b0;
        wr_ptr    <= frame_start;
      end else if (pair_done) begin
        wr_ptr <= ADDR_W'(ptr_next(int'(wr_ptr), STORE_WORDS));
        if (mb_last_word) begin
          wim_cnt <= '0;
          mb_cnt  <= mb_cnt + 1'b1;
        end else begin
          wim_cnt <= wim_cnt + 1'b1;
        end
        if (frame_done) rx_active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mfa_disp_sel.sv
module mfa_disp_sel #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_base,
  input  logic              field_end,
  output logic [ADDR_W-1:0] disp_base,
  output logic              pending
);
  logic [ADDR_W-1:0] pend_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      pend_base <= '0;
      disp_base <= '0;
    end else begin
      if (field_end && pending) begin
        disp_base <= pend_base;
        pending   <= 1'b0;
      end
      if (commit) begin
        pend_base <= commit_base;
        pending   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mb_frame_acceptor.sv
module mb_frame_acceptor #(
  parameter int MB_BYTES    = 384,
  parameter int CIF_MBS     = 396,
  parameter int QCIF_MBS    = 99,
  parameter int STORE_WORDS = 262144,
  localparam int ADDR_W     = $clog2(STORE_WORDS),
  localparam int WPM        = MB_BYTES / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cif_mode,
  input  logic              frame_sync,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              field_end,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic [ADDR_W-1:0] disp_base,
  output logic              frame_commit,
  output logic              sync_err
);
  logic              byte_acc, sync_rise, early_drop, frame_done, pair_done, pending;
  logic [15:0]       word;
  logic [ADDR_W-1:0] wr_ptr, frame_start;

  mfa_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(sync_rise), .byte_acc(byte_acc),
    .byte_in(byte_in), .pair_done(pair_done), .word(word)
  );

  mfa_frame_ctl #(
    .STORE_WORDS(STORE_WORDS), .ADDR_W(ADDR_W), .WPM(WPM),
    .CIF_MBS(CIF_MBS), .QCIF_MBS(QCIF_MBS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cif_mode(cif_mode), .frame_sync(frame_sync),
    .byte_stb(byte_stb), .pair_done(pair_done), .byte_acc(byte_acc),
    .sync_rise(sync_rise), .early_drop(early_drop), .frame_done(frame_done),
    .wr_ptr(wr_ptr), .frame_start(frame_start)
  );

  mfa_disp_sel #(.ADDR_W(ADDR_W)) u_disp (
    .clk(clk), .rst_n(rst_n), .commit(frame_done), .commit_base(frame_start),
    .field_end(field_end), .disp_base(disp_base), .pending(pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      frame_commit <= 1'b0;
      sync_err     <= 1'b0;
    end else begin
      wr_en        <= pair_done;
      frame_commit <= frame_done;
      if (pair_done) begin
        wr_addr <= wr_ptr;
        wr_data <= word;
      end
      if (early_drop)      sync_err <= 1'b1;
      else if (frame_done) sync_err <= 1'b0;
    end
  end
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              byte_stb,
  input logic              field_end,
  input logic              wr_en,
  input logic              frame_commit,
  input logic              sync_err,
  input logic              early_drop,
  input logic [ADDR_W-1:0] disp_base,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] frame_start
);
  AST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);                                   // R3
  AST_WR_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(frame_sync));                              // R3
  AST_DROP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    early_drop |=> (wr_ptr == $past(frame_start)));            // R5
  AST_DROP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    early_drop |=> (sync_err && !frame_commit));               // R5
  AST_COMMIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |-> !sync_err);                               // R6
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(disp_base));                        // R7
endmodule

bind mb_frame_acceptor mfa_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .byte_stb(byte_stb),
  .field_end(field_end), .wr_en(wr_en), .frame_commit(frame_commit),
  .sync_err(sync_err), .early_drop(early_drop), .disp_base(disp_base),
  .wr_ptr(wr_ptr), .frame_start(frame_start)
);

// File: tb/tb_mb_frame_acceptor.sv
module tb_mb_frame_acceptor;
  localparam int MBB = 4, CIFN = 6, QCIFN = 3, DEPTH = 40;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cif_mode = 1'b0, frame_sync = 1'b0, byte_stb = 1'b0, field_end = 1'b0;
  logic [7:0] byte_in = '0;
  logic wr_en, frame_commit, sync_err;
  logic [AW-1:0] wr_addr, disp_base;
  logic [15:0] wr_data;

  int checks = 0, errors = 0;
  int mptr = 0, mdisp = 0, mpbase = 0;
  bit mpend = 0, merr = 0;

  always #10 clk = !clk;

  mb_frame_acceptor #(.MB_BYTES(MBB), .CIF_MBS(CIFN), .QCIF_MBS(QCIFN), .STORE_WORDS(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cif_mode(cif_mode), .frame_sync(frame_sync),
    .byte_stb(byte_stb), .byte_in(byte_in), .field_end(field_end),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .disp_base(disp_base),
    .frame_commit(frame_commit), .sync_err(sync_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int fwords(input bit cif);
    return (cif ? CIFN : QCIFN) * MBB / 2;
  endfunction

  // one byte on the strobe, then three idle cycles
  task automatic put_byte(input logic [7:0] b, output bit wr, output int a, output int d, output bit cm);
    byte_in = b; byte_stb = 1'b1;
    tick();
    byte_stb = 1'b0;
    wr = wr_en; a = int'(wr_addr); d = int'(wr_data); cm = frame_commit;
    tick(); tick(); tick();
  endtask

  // nwords < full frame means sync is dropped early
  task automatic send_frame(input bit cif, input int nwords, input int seed);
    bit wr, cm; int a, d;
    int start = mptr;
    bit full = (nwords == fwords(cif));
    cif_mode = cif; frame_sync = 1'b1;
    tick();
    cif_mode = !cif;  // mode is only sampled at the sync edge
    for (int w = 0; w < nwords; w++) begin
      logic [7:0] hb = 8'(seed + 2*w), lb = 8'(seed + 2*w + 1);
      bit last = full && (w == nwords - 1);
      put_byte(hb, wr, a, d, cm);
      chk("R1 no write on first byte", int'(wr), 0);
      put_byte(lb, wr, a, d, cm);
      chk("R1 write on second byte", int'(wr), 1);
      chk("R1 word data high-first", d, {hb, lb});
      chk(w == 0 ? "R2 first word at frame start" : "R8 address step/wrap", a, mptr);
      chk("R4 commit only on last word", int'(cm), int'(last));
      if (last) begin merr = 0; mpend = 1; mpbase = start; end
      chk("R6 error flag", int'(sync_err), int'(merr));
      mptr = (mptr + 1) % DEPTH;
    end
    if (full) begin
      put_byte(8'hEE, wr, a, d, cm);
      put_byte(8'hDD, wr, a, d, cm);
      chk("R4 bytes after completion ignored", int'(wr), 0);
      frame_sync = 1'b0; tick();
    end else begin
      frame_sync = 1'b0; tick();
      chk("R5 error set on early fall", int'(sync_err), 1);
      chk("R5 no commit on drop", int'(frame_commit), 0);
      merr = 1; mptr = start;
    end
  endtask

  task automatic pulse_field_end();
    field_end = 1'b1; tick(); field_end = 1'b0;
    if (mpend) begin mdisp = mpbase; mpend = 0; end
    chk("R7 display base after field end", int'(disp_base), mdisp);
    tick();
    chk("R7 display base holds", int'(disp_base), mdisp);
  endtask

  initial begin
    bit wr, cm; int a, d;
    repeat (3) @(negedge clk);
    chk("R9 reset wr_en", int'(wr_en), 0);
    chk("R9 reset commit", int'(frame_commit), 0);
    chk("R9 reset sync_err", int'(sync_err), 0);
    chk("R9 reset disp_base", int'(disp_base), 0);
    rst_n = 1'b1; tick();

    send_frame(1'b0, fwords(1'b0), 8'h10);   // small frame at 0
    pulse_field_end();
    send_frame(1'b1, fwords(1'b1), 8'h40);   // large frame at 6
    chk("R7 no switch before field end", int'(disp_base), 0);
    pulse_field_end();
    pulse_field_end();                        // nothing pending

    put_byte(8'h77, wr, a, d, cm);           // R3 strobes with sync low
    put_byte(8'h78, wr, a, d, cm);
    chk("R3 bytes with sync low ignored", int'(wr), 0);

    send_frame(1'b0, 3, 8'h80);              // R5 dropped at 18
    pulse_field_end();
    send_frame(1'b1, fwords(1'b1), 8'hA0);   // R5 restart at 18, R6 clear
    send_frame(1'b0, fwords(1'b0), 8'hC0);   // at 30
    pulse_field_end();                        // R7 latest = 30
    send_frame(1'b1, fwords(1'b1), 8'h20);   // R8 36..39,0..7
    pulse_field_end();
    send_frame(1'b0, fwords(1'b0), 8'h60);   // continues at 8
    pulse_field_end();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule